// File: doc/BRIEF.md
# Disk Card Bit-Addressed Control Register with Motor Timer

This block is the single-bit serial I/O register of a floppy interface card. The host addresses one bit at a time. Each write stores one data bit into a control flip-flop, chosen by a three-bit field of the address. The stored controls drive the rest of the card: card enable, wait-state arming, head load, side choice and three drive-select lines. The same register can be read back as one status byte.

A retriggerable monoflop produces one motor-enable line shared by every drive. Only a 0-to-1 change of the motor trigger bit starts or restarts the timer, so writing 1 to a bit that already holds 1 does nothing. The controller's forced-ready input uses the same line, and every drive receives it as an active-low motor-on line. When software sets more than one drive-select bit, a priority stage passes only the highest-numbered drive. It produces a one-hot active-drive vector and a flag that is set when no drive is selected.

Top module: `disk_ctl_bitreg`

## Requirements
- R1: An access hits the block only when `io_addr[15:8]` equals `BASE_ADDR[15:8]` (0x11 by default). The written bit index is `io_addr[3:1]`, and `io_addr[0]` is ignored. A write that misses leaves every output unchanged.
- R2: Bit index 0 sets `card_sel`, index 2 sets `wait_en`, index 3 sets `head_load` and index 7 sets `side_sel`. Each output takes the written data bit from the cycle after the write.
- R3: Bit indices 4, 5 and 6 set `drive_sel[0]`, `drive_sel[1]` and `drive_sel[2]`, which select drives 1, 2 and 3.
- R4: A write of 1 to bit index 1, when the last value written to that index was 0, reloads the timer. `motor_en` is then high for exactly `MOTOR_CYCLES` cycles, starting in the cycle after the write. This also applies while the timer is already running.
- R5: A write of 1 to bit index 1 when the last value written there was 1 leaves the timer alone. A write of 0 there only records the new last value.
- R6: Every bit of `motor_on_n` is the inverse of `motor_en`.
- R7: `status_byte` holds head load in bit 0, `drive_sel[2:0]` in bits 3:1, the inverse of `motor_en` in bit 4, a constant 0 in bit 5, a constant 1 in bit 6 and the side in bit 7. `status_valid` is high when the address hits and `io_addr[2:0]` is 0.
- R8: `drive_act` is one-hot on the highest set bit of `drive_sel`. It is all zero, with `drive_none` high, when no select bit is set.
- R9: After reset, all controls, the motor timer and the last-value history of the trigger bit are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | Serial I/O bit address |
| io_wr | input | 1 | Write strobe for one bit |
| io_wdata | input | 1 | Bit value written |
| io_hit | output | 1 | Address falls in this block's range |
| status_valid | output | 1 | Status byte is addressed |
| status_byte | output | 8 | Readback byte |
| card_sel | output | 1 | Card enable |
| wait_en | output | 1 | Wait-state arming |
| head_load | output | 1 | Head load request |
| side_sel | output | 1 | Selected disk side |
| motor_en | output | 1 | Shared motor enable, also forced-ready |
| motor_on_n | output | 3 | Active-low motor-on line of each drive |
| drive_sel | output | 3 | Raw drive-select bits |
| drive_act | output | 3 | One-hot resolved drive |
| drive_none | output | 1 | No drive selected |

## Verification
The assertions check the following on every cycle:
- `drive_act` is one-hot or zero, and the no-drive flag agrees with it.
- The constant status bits and the inverted motor bit match `motor_en`.
- Every motor-on line is the inverse of `motor_en`.
- A missed or absent write leaves the controls unchanged.
- Each new start of the motor follows a trigger write.

Some behaviours need the bench's scenarios and cycle model:
- the exact length of the motor window;
- a restart in the middle of a run;
- a repeated 1 that must not extend the run;
- a 0-then-1 sequence that must restart it;
- a reset in the middle of a run.

// File: rtl/disk_ctl_bitreg_pkg.sv
package disk_ctl_bitreg_pkg;

    localparam int unsigned NUM_DRIVES = 3;
    localparam int unsigned IDX_W      = 3;

    typedef enum logic [IDX_W-1:0] {
        IDX_CARD  = 3'd0,
        IDX_MOTOR = 3'd1,
        IDX_WAIT  = 3'd2,
        IDX_HEAD  = 3'd3,
        IDX_DRV1  = 3'd4,
        IDX_DRV2  = 3'd5,
        IDX_DRV3  = 3'd6,
        IDX_SIDE  = 3'd7
    } bit_idx_e;

    typedef struct packed {
        logic                  card;
        logic                  wait_arm;
        logic                  head;
        logic                  side;
        logic [NUM_DRIVES-1:0] dsel;
    } ctl_regs_t;

endpackage

// File: rtl/disk_ctl_bitreg_decode.sv
module disk_ctl_bitreg_decode
    import disk_ctl_bitreg_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR = 16'h1100
) (
    input  logic [15:0]      addr_i,
    input  logic             wr_i,
    output logic             hit_o,
    output logic             wr_hit_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             rd_hit_o
);
    localparam logic [7:0] PAGE = BASE_ADDR[15:8];

    always_comb begin
        hit_o    = (addr_i[15:8] == PAGE);
        wr_hit_o = hit_o && wr_i;
        idx_o    = addr_i[IDX_W:1];
        rd_hit_o = hit_o && (addr_i[2:0] == 3'b000);
    end
endmodule

// File: rtl/disk_ctl_bitreg_monoflop.sv
module disk_ctl_bitreg_monoflop #(
    parameter int unsigned MOTOR_CYCLES = 4230000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_wr_i,
    input  logic trig_val_i,
    output logic active_o
);
    localparam int unsigned CNT_W = $clog2(MOTOR_CYCLES + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(MOTOR_CYCLES);

    typedef struct packed {
        logic             last;
        logic [CNT_W-1:0] cnt;
    } mf_state_t;

    mf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (trig_wr_i) begin
            if (trig_val_i && !st_q.last) begin
                st_d.cnt = RELOAD;
            end
            st_d.last = trig_val_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = (st_q.cnt != '0);
endmodule

// File: rtl/disk_ctl_bitreg_drvpick.sv
module disk_ctl_bitreg_drvpick #(
    parameter int unsigned N = 3
) (
    input  logic [N-1:0] sel_i,
    output logic [N-1:0] act_o,
    output logic         none_o
);
    logic [N:0] higher;

    assign higher[N] = 1'b0;

    for (genvar g = N - 1; g >= 0; g--) begin : g_prio
        assign act_o[g]  = sel_i[g] && !higher[g+1];
        assign higher[g] = higher[g+1] || sel_i[g];
    end

    assign none_o = !higher[0];
endmodule

// File: rtl/disk_ctl_bitreg.sv
module disk_ctl_bitreg
    import disk_ctl_bitreg_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR    = 16'h1100,
    parameter int unsigned MOTOR_CYCLES = 4230000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [15:0]           io_addr,
    input  logic                  io_wr,
    input  logic                  io_wdata,
    output logic                  io_hit,
    output logic                  status_valid,
    output logic [7:0]            status_byte,
    output logic                  card_sel,
    output logic                  wait_en,
    output logic                  head_load,
    output logic                  side_sel,
    output logic                  motor_en,
    output logic [NUM_DRIVES-1:0] motor_on_n,
    output logic [NUM_DRIVES-1:0] drive_sel,
    output logic [NUM_DRIVES-1:0] drive_act,
    output logic                  drive_none
);
    logic             wr_hit;
    logic [IDX_W-1:0] idx;
    logic             motor_wr;
    ctl_regs_t        ctl_d, ctl_q;

    disk_ctl_bitreg_decode #(.BASE_ADDR(BASE_ADDR)) u_dec (
        .addr_i   (io_addr),
        .wr_i     (io_wr),
        .hit_o    (io_hit),
        .wr_hit_o (wr_hit),
        .idx_o    (idx),
        .rd_hit_o (status_valid)
    );

    assign motor_wr = wr_hit && (idx == IDX_MOTOR);

    disk_ctl_bitreg_monoflop #(.MOTOR_CYCLES(MOTOR_CYCLES)) u_mf (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_wr_i  (motor_wr),
        .trig_val_i (io_wdata),
        .active_o   (motor_en)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (wr_hit) begin
            unique case (bit_idx_e'(idx))
                IDX_CARD:  ctl_d.card     = io_wdata;
                IDX_WAIT:  ctl_d.wait_arm = io_wdata;
                IDX_HEAD:  ctl_d.head     = io_wdata;
                IDX_DRV1:  ctl_d.dsel[0]  = io_wdata;
                IDX_DRV2:  ctl_d.dsel[1]  = io_wdata;
                IDX_DRV3:  ctl_d.dsel[2]  = io_wdata;
                IDX_SIDE:  ctl_d.side     = io_wdata;
                default:   ctl_d          = ctl_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    disk_ctl_bitreg_drvpick #(.N(NUM_DRIVES)) u_pick (
        .sel_i  (ctl_q.dsel),
        .act_o  (drive_act),
        .none_o (drive_none)
    );

    assign card_sel   = ctl_q.card;
    assign wait_en    = ctl_q.wait_arm;
    assign head_load  = ctl_q.head;
    assign side_sel   = ctl_q.side;
    assign drive_sel  = ctl_q.dsel;
    assign motor_on_n = {NUM_DRIVES{~motor_en}};

    assign status_byte = {ctl_q.side, 1'b1, 1'b0, ~motor_en, ctl_q.dsel, ctl_q.head};
endmodule

// File: rtl/disk_ctl_bitreg_chk.sv
module disk_ctl_bitreg_chk #(
    parameter logic [15:0] BASE_ADDR = 16'h1100
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] io_addr,
    input logic        io_wr,
    input logic        io_wdata,
    input logic        io_hit,
    input logic        status_valid,
    input logic [7:0]  status_byte,
    input logic        card_sel,
    input logic        wait_en,
    input logic        head_load,
    input logic        side_sel,
    input logic        motor_en,
    input logic [2:0]  motor_on_n,
    input logic [2:0]  drive_sel,
    input logic [2:0]  drive_act,
    input logic        drive_none
);
    logic trig_wr;
    assign trig_wr = io_wr && (io_addr[15:8] == BASE_ADDR[15:8]) && (io_addr[3:1] == 3'd1) && io_wdata;

    assert_act_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drive_act) && ((drive_act == 3'b000) == (drive_sel == 3'b000)));

    assert_none_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        drive_none |-> (drive_sel == 3'b000));

    assert_status_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[6] && !status_byte[5] && (status_byte[4] == !motor_en));

    assert_motor_lines_R6: assert property (@(posedge clk) disable iff (!rst_n)
        motor_on_n == {3{~motor_en}});

    assert_start_needs_trigger_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(motor_en) |-> $past(trig_wr));

    assert_miss_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_addr[15:8] == BASE_ADDR[15:8]) |=>
            ($stable(card_sel) && $stable(wait_en) && $stable(head_load) &&
             $stable(side_sel) && $stable(drive_sel)));

    assert_reset_clear_R9: assert property (@(posedge clk)
        $rose(rst_n) |-> (!motor_en && !card_sel && !wait_en && drive_sel == 3'b000));
endmodule

bind disk_ctl_bitreg disk_ctl_bitreg_chk #(.BASE_ADDR(BASE_ADDR)) u_chk (.*);

// File: tb/disk_ctl_bitreg_test.sv
module disk_ctl_bitreg_test;
    localparam int CLK_PERIOD = 10;
    localparam int MC         = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = 16'h0000;
    logic        io_wr = 1'b0;
    logic        io_wdata = 1'b0;
    logic        io_hit, status_valid, card_sel, wait_en, head_load, side_sel, motor_en, drive_none;
    logic [7:0]  status_byte;
    logic [2:0]  motor_on_n, drive_sel, drive_act;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    bit m_card, m_wait, m_head, m_side, m_last;
    bit [2:0] m_dsel;
    int m_cnt;

    disk_ctl_bitreg #(.BASE_ADDR(16'h1100), .MOTOR_CYCLES(MC)) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_card = 0; m_wait = 0; m_head = 0; m_side = 0; m_last = 0;
            m_dsel = 0; m_cnt = 0;
        end else begin
            if (m_cnt > 0) m_cnt = m_cnt - 1;
            if (io_wr && io_addr[15:8] == 8'h11) begin
                case ((io_addr >> 1) & 7)
                    0: m_card = io_wdata;
                    1: begin
                        if (io_wdata && !m_last) m_cnt = MC;
                        m_last = io_wdata;
                    end
                    2: m_wait = io_wdata;
                    3: m_head = io_wdata;
                    4: m_dsel[0] = io_wdata;
                    5: m_dsel[1] = io_wdata;
                    6: m_dsel[2] = io_wdata;
                    default: m_side = io_wdata;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit mon;
            bit [2:0] act;
            bit [7:0] st;
            mon = (m_cnt > 0);
            act = m_dsel[2] ? 3'b100 : m_dsel[1] ? 3'b010 : m_dsel[0] ? 3'b001 : 3'b000;
            st  = {m_side, 1'b1, 1'b0, ~mon, m_dsel, m_head};
            chk(io_hit == (io_addr[15:8] == 8'h11), "R1 io_hit", io_hit, io_addr[15:8] == 8'h11);
            chk(card_sel == m_card, "R2 card_sel", card_sel, m_card);
            chk(wait_en == m_wait, "R2 wait_en", wait_en, m_wait);
            chk(head_load == m_head, "R2 head_load", head_load, m_head);
            chk(side_sel == m_side, "R2 side_sel", side_sel, m_side);
            chk(drive_sel == m_dsel, "R3 drive_sel", drive_sel, m_dsel);
            chk(motor_en == mon, "R4 R5 motor_en", motor_en, mon);
            chk(motor_on_n == {3{~mon}}, "R6 motor_on_n", motor_on_n, {3{~mon}});
            chk(status_byte == st, "R7 status_byte", status_byte, st);
            chk(status_valid == (io_addr[15:8] == 8'h11 && io_addr[2:0] == 0), "R7 status_valid",
                status_valid, io_addr[15:8] == 8'h11 && io_addr[2:0] == 0);
            chk(drive_act == act, "R8 drive_act", drive_act, act);
            chk(drive_none == (m_dsel == 0), "R8 drive_none", drive_none, m_dsel == 0);
        end
    end

    task automatic wr(input logic [15:0] a, input bit d);
        @(negedge clk); #1;
        io_addr = a; io_wr = 1'b1; io_wdata = d;
        @(negedge clk); #1;
        io_wr = 1'b0; io_wdata = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] ba(input int idx);
        return 16'h1100 | 16'(idx << 1);
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(status_byte == 8'h50, "R9 reset status", status_byte, 8'h50);
        // R2 individual controls, including odd address (R1 bit 0 ignored)
        wr(ba(0), 1); wr(ba(2), 1); wr(16'h1107, 1); wr(ba(7), 1);
        wr(ba(2), 0);
        // R1 misses
        wr(16'h1200 | 16'(0 << 1), 0); wr(16'h0100, 0); wr(16'h110E ^ 16'h0100, 0);
        wr(16'h2106, 0);
        idle(2);
        // R3 R8 drive selection patterns
        wr(ba(4), 1); wr(ba(6), 1); wr(ba(5), 1); wr(ba(6), 0); wr(ba(5), 0);
        wr(ba(4), 0); wr(ba(5), 1); idle(1);
        // R4 motor window expiry
        wr(ba(1), 1); idle(MC + 4);
        // R5 repeated 1 does not restart
        wr(ba(1), 1); idle(4);
        // R4 0 then 1 restarts
        wr(ba(1), 0); wr(ba(1), 1); idle(8);
        // R4 retrigger mid run
        wr(ba(1), 0); wr(ba(1), 1); idle(8);
        // R5 repeated 1 during run
        wr(ba(1), 1); idle(MC);
        // R1 write to motor index on wrong page
        wr(16'h1202, 0); wr(16'h1202, 1); idle(3);
        // R7 readback address in window
        @(negedge clk); #1 io_addr = 16'h1100; idle(2);
        #1 io_addr = 16'h1108; idle(2);
        // R9 reset mid run
        wr(ba(1), 0); wr(ba(1), 1); idle(3);
        @(negedge clk); #1 rst_n = 1'b0;
        @(negedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(motor_en == 0 && card_sel == 0 && drive_sel == 0, "R9 reset mid run",
            {motor_en, card_sel, drive_sel}, 0);
        // R9 history cleared: a 1 now restarts
        wr(ba(1), 1); idle(MC + 2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule